// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block lets an outside bus master borrow the external address and data buses of a small processor without the CPU taking part. An active-low request pin is brought into the oscillator clock domain, and a small state machine grants the bus only between CPU bus cycles. While it grants the bus, it stalls the CPU, turns off the address and data pad drivers and holds the read and write strobes at a driven high level. An active-low acknowledge output tells the outside master that the bus is free.

The processor clock is the oscillator divided by two. The block produces that clock itself and keeps it toggling at all times, so peripherals and the outside logic keep a timing reference during a grant. The state machine advances only on processor clock phases. The whole feature depends on a mode enable bit. It is switched off when the acknowledge pin serves a different function.

Top module: `busgrant_ctrl`

## Requirements
- R1: After reset the outputs are as follows: acknowledge `gnt_ack_n_o` is 1, `cpu_stall_o` is 0, every bit of `addr_oe_o` is 1 and `proc_clk_o` is 0.
- R2: When `grant_en_i` is 0 or `ack_alt_i` is 1, a low request has no effect. Acknowledge stays 1, the stall stays 0 and the pads keep following the CPU.
- R3: When the feature is enabled and `req_n_i` is low with no CPU bus cycle in progress, acknowledge goes low within 8 oscillator cycles. It stays low for as long as the request stays low.
- R4: Whenever acknowledge is low, every bit of `addr_oe_o` and `data_oe_o` is 0.
- R5: Whenever acknowledge is low, `rd_n_o` and `wr_n_o` are both 1.
- R6: `proc_clk_o` changes level on every oscillator cycle after reset, including during a grant.
- R7: Acknowledge does not go low while `cpu_busy_i` reports a bus cycle in progress. Once the request has been seen, `cpu_stall_o` is 1 so that no new cycle starts.
- R8: After the request returns high, acknowledge rises within 8 oscillator cycles. The pad drivers stay off for the first oscillator cycle after that rise. The drivers are restored and the stall is released exactly 2 oscillator cycles after the rise.
- R9: While `cpu_stall_o` is 0, `addr_o`, `data_o`, `rd_n_o` and `wr_n_o` equal the CPU-side inputs, and `data_oe_o` equals `cpu_data_oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_en_i | input | 1 | Mode enable for the hold feature |
| ack_alt_i | input | 1 | Acknowledge pin used for its alternate flag function |
| req_n_i | input | 1 | Asynchronous active-low bus request from outside |
| cpu_busy_i | input | 1 | CPU bus cycle in progress |
| cpu_addr_i | input | ADDR_W | CPU address |
| cpu_data_i | input | DATA_W | CPU write data |
| cpu_data_oe_i | input | 1 | CPU wants to drive the data pins |
| cpu_rd_n_i | input | 1 | CPU read strobe, active low |
| cpu_wr_n_i | input | 1 | CPU write strobe, active low |
| proc_clk_o | output | 1 | Processor clock, oscillator divided by two |
| addr_o | output | ADDR_W | Address pad value |
| addr_oe_o | output | ADDR_W/PORT_W | Address pad output enable, one per 8-bit port |
| data_o | output | DATA_W | Data pad value |
| data_oe_o | output | 1 | Data pad output enable |
| rd_n_o | output | 1 | Read strobe pad |
| wr_n_o | output | 1 | Write strobe pad |
| gnt_ack_n_o | output | 1 | Active-low bus grant acknowledge |
| cpu_stall_o | output | 1 | Holds the CPU off the bus |

## Verification
Two things can meet in one processor phase: a request that arrives while a CPU cycle is still finishing, and a request that is withdrawn just as the grant is about to be made. The directed part of the bench holds `cpu_busy_i` high under a live request. It then drops `cpu_busy_i` and checks that acknowledge arrives only after the busy signal has fallen. The random part toggles the request and busy inputs independently on random cycles, so that withdrawals land in every state. In every cycle the bench checks that acknowledge and the pad enables are never active together and that the strobes are high during a grant.

// File: rtl/busgrant_pkg.sv
// Package busgrant_pkg
// Shared types for the bus grant controller.
// Assumes: the grant state machine encodes four states in two bits.
package busgrant_pkg;
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,  // CPU owns the bus
        GS_DRAIN = 2'd1,  // request seen, CPU stalled, waiting for cycle end
        GS_GRANT = 2'd2,  // pads released, acknowledge low
        GS_RETURN = 2'd3  // acknowledge high again, pads still released
    } grant_state_e;
endpackage

// File: rtl/busgrant_sync.sv
// Module busgrant_sync
// Synchronises an asynchronous active-low request into the clk domain.
// Assumes: the input may change at any time; the output idles at 1.
module busgrant_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the request through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_n_i};
        end
    end

    assign sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/busgrant_phase.sv
// Module busgrant_phase
// Divides the oscillator by two to make the processor clock. It also
// gives a one-cycle phase strobe at which processor-phase logic may advance.
// Assumes: runs free and is never gated by the grant logic.
module busgrant_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o,
    output logic step_o
);
    logic phase_q;

    // Toggle the processor clock on every oscillator edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign phase_o = phase_q;
    assign step_o  = phase_q;
endmodule

// File: rtl/busgrant_fsm.sv
// Module busgrant_fsm
// Handshake state machine: it stalls the CPU, waits for the bus cycle to end,
// grants the bus, and on withdrawal raises acknowledge one phase before
// giving the pads back.
// Assumes: req_i is already synchronised and gated by the mode bits;
// the state only advances when step_i is high.
module busgrant_fsm
    import busgrant_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         req_i,
    input  logic         busy_i,
    output grant_state_e state_o
);
    grant_state_e state_q, state_d;

    // Choose the next grant state from the request and the cycle status.
    always_comb begin
        state_d = state_q;
        case (state_q)
            GS_IDLE:   if (req_i) state_d = GS_DRAIN;
            GS_DRAIN: begin
                if (!req_i)       state_d = GS_IDLE;
                else if (!busy_i) state_d = GS_GRANT;
            end
            GS_GRANT:  if (!req_i) state_d = GS_RETURN;
            GS_RETURN: state_d = GS_IDLE;
            default:   state_d = GS_IDLE;
        endcase
    end

    // Register the state once per processor phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else if (step_i) begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/busgrant_pads.sv
// Module busgrant_pads
// Pad-side steering: it passes the CPU values through while the CPU owns the
// bus. Otherwise it turns off the address and data enables and drives the
// strobes high.
// Assumes: the address bus is split into ports of PORT_W bits each.
module busgrant_pads #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_W = 8,
    localparam int NPORT = ADDR_W / PORT_W
) (
    input  logic              own_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_data_i,
    input  logic              cpu_data_oe_i,
    input  logic              cpu_rd_n_i,
    input  logic              cpu_wr_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NPORT-1:0]  addr_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              rd_n_o,
    output logic              wr_n_o
);
    // One enable for each address port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign addr_oe_o[p] = own_i;
    end

    // Values always follow the CPU; only the enables gate the pads.
    always_comb begin
        addr_o    = cpu_addr_i;
        data_o    = cpu_data_i;
        data_oe_o = own_i & cpu_data_oe_i;
        rd_n_o    = own_i ? cpu_rd_n_i : 1'b1;
        wr_n_o    = own_i ? cpu_wr_n_i : 1'b1;
    end
endmodule

// File: rtl/busgrant_ctrl.sv
// Module busgrant_ctrl
// Top of the bus hold handshake controller. It synchronises the request,
// gates it with the mode bits, runs the handshake state machine on
// processor phases, and steers the pads.
// Assumes: clk is the oscillator; the processor clock is clk divided by two.
module busgrant_ctrl
    import busgrant_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       grant_en_i,
    input  logic                       ack_alt_i,
    input  logic                       req_n_i,
    input  logic                       cpu_busy_i,
    input  logic [ADDR_W-1:0]          cpu_addr_i,
    input  logic [DATA_W-1:0]          cpu_data_i,
    input  logic                       cpu_data_oe_i,
    input  logic                       cpu_rd_n_i,
    input  logic                       cpu_wr_n_i,
    output logic                       proc_clk_o,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [ADDR_W/PORT_W-1:0]   addr_oe_o,
    output logic [DATA_W-1:0]          data_o,
    output logic                       data_oe_o,
    output logic                       rd_n_o,
    output logic                       wr_n_o,
    output logic                       gnt_ack_n_o,
    output logic                       cpu_stall_o
);
    logic         req_sync_n;
    logic         step;
    logic         req_live;
    logic         own;
    grant_state_e state;

    busgrant_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (req_n_i),
        .sync_n_o  (req_sync_n)
    );

    busgrant_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (proc_clk_o),
        .step_o  (step)
    );

    // The request counts only when the feature is on and the pin is not in its alternate use.
    assign req_live = ~req_sync_n & grant_en_i & ~ack_alt_i;

    busgrant_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .req_i   (req_live),
        .busy_i  (cpu_busy_i),
        .state_o (state)
    );

    // Decode bus ownership, acknowledge and stall from the state.
    always_comb begin
        own         = (state == GS_IDLE) || (state == GS_DRAIN);
        gnt_ack_n_o = (state != GS_GRANT);
        cpu_stall_o = (state != GS_IDLE);
    end

    busgrant_pads #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_pads (
        .own_i         (own),
        .cpu_addr_i    (cpu_addr_i),
        .cpu_data_i    (cpu_data_i),
        .cpu_data_oe_i (cpu_data_oe_i),
        .cpu_rd_n_i    (cpu_rd_n_i),
        .cpu_wr_n_i    (cpu_wr_n_i),
        .addr_o        (addr_o),
        .addr_oe_o     (addr_oe_o),
        .data_o        (data_o),
        .data_oe_o     (data_oe_o),
        .rd_n_o        (rd_n_o),
        .wr_n_o        (wr_n_o)
    );
endmodule

// File: rtl/busgrant_checker.sv
// Module busgrant_checker
// Property checks on the port behaviour of busgrant_ctrl, bound to it.
// Assumes: clk is the oscillator and rst_n is the synchronous reset.
module busgrant_checker #(
    parameter int OE_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            proc_clk_o,
    input logic            gnt_ack_n_o,
    input logic [OE_W-1:0] addr_oe_o,
    input logic            data_oe_o,
    input logic            rd_n_o,
    input logic            wr_n_o,
    input logic            cpu_stall_o,
    input logic            cpu_busy_i
);
    a_r4_pads_off_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_ack_n_o |-> (addr_oe_o == '0) && !data_oe_o);

    a_r5_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_ack_n_o |-> rd_n_o && wr_n_o);

    a_r6_clock_runs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> proc_clk_o != $past(proc_clk_o));

    a_r7_grant_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_ack_n_o) |-> !$past(cpu_busy_i));

    a_r7_stalled_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_ack_n_o |-> cpu_stall_o);

    a_r8_ack_before_drivers: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_ack_n_o) |-> (addr_oe_o == '0) && cpu_stall_o);
endmodule

bind busgrant_ctrl busgrant_checker #(.OE_W(ADDR_W / PORT_W)) u_busgrant_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .proc_clk_o  (proc_clk_o),
    .gnt_ack_n_o (gnt_ack_n_o),
    .addr_oe_o   (addr_oe_o),
    .data_oe_o   (data_oe_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .cpu_stall_o (cpu_stall_o),
    .cpu_busy_i  (cpu_busy_i)
);

// File: tb/busgrant_ctrl_tb_top.sv
// Bench for busgrant_ctrl: directed corner cases plus seeded random stimulus.
// Inputs change 1 ns after the rising edge; outputs are sampled on the falling edge.
module busgrant_ctrl_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PORT_W = 8;
    localparam int NPORT  = ADDR_W / PORT_W;
    localparam int LIMIT  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_en_i = 1'b1, ack_alt_i = 1'b0, req_n_i = 1'b1, cpu_busy_i = 1'b0;
    logic [ADDR_W-1:0] cpu_addr_i = '0;
    logic [DATA_W-1:0] cpu_data_i = '0;
    logic cpu_data_oe_i = 1'b0, cpu_rd_n_i = 1'b1, cpu_wr_n_i = 1'b1;
    logic proc_clk_o;
    logic [ADDR_W-1:0] addr_o;
    logic [NPORT-1:0] addr_oe_o;
    logic [DATA_W-1:0] data_o;
    logic data_oe_o, rd_n_o, wr_n_o, gnt_ack_n_o, cpu_stall_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic prev_clk;

    always #10 clk = ~clk;

    busgrant_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .grant_en_i(grant_en_i), .ack_alt_i(ack_alt_i),
        .req_n_i(req_n_i), .cpu_busy_i(cpu_busy_i), .cpu_addr_i(cpu_addr_i),
        .cpu_data_i(cpu_data_i), .cpu_data_oe_i(cpu_data_oe_i),
        .cpu_rd_n_i(cpu_rd_n_i), .cpu_wr_n_i(cpu_wr_n_i), .proc_clk_o(proc_clk_o),
        .addr_o(addr_o), .addr_oe_o(addr_oe_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .gnt_ack_n_o(gnt_ack_n_o),
        .cpu_stall_o(cpu_stall_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected pad values while the CPU owns the bus.
    function automatic logic [1:0] exp_strobes(input logic rd, input logic wr);
        return {rd, wr};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Per-cycle monitor of the rules that must always hold.
    always @(negedge clk) begin
        if (mon_on) begin
            check(proc_clk_o != prev_clk, "R6 clock toggles", proc_clk_o, !prev_clk);
            if (!gnt_ack_n_o) begin
                check(addr_oe_o == '0 && !data_oe_o, "R4 pads off in grant",
                      {addr_oe_o, data_oe_o}, 0);
                check({rd_n_o, wr_n_o} == 2'b11, "R5 strobes high in grant",
                      {rd_n_o, wr_n_o}, 3);
            end
            if (!cpu_stall_o) begin
                check(addr_o == cpu_addr_i && data_o == cpu_data_i &&
                      data_oe_o == cpu_data_oe_i &&
                      {rd_n_o, wr_n_o} == exp_strobes(cpu_rd_n_i, cpu_wr_n_i),
                      "R9 pass-through", {addr_o, data_o, rd_n_o, wr_n_o},
                      {cpu_addr_i, cpu_data_i, cpu_rd_n_i, cpu_wr_n_i});
            end
        end
        prev_clk = proc_clk_o;
    end

    // Wait for acknowledge to reach a level within a bound; returns cycles waited or -1.
    task automatic wait_ack(input logic lvl, input int bound, output int got);
        got = -1;
        for (int i = 0; i <= bound; i++) begin
            @(negedge clk);
            if (gnt_ack_n_o == lvl) begin
                got = i;
                break;
            end
        end
    endtask

    // Release a grant and check the order of acknowledge, drivers and stall (R8).
    task automatic release_and_check();
        int got;
        req_n_i = 1'b1;
        wait_ack(1'b1, LIMIT, got);
        check(got >= 0, "R8 ack rises in bound", got, LIMIT);
        check(addr_oe_o == '0, "R8 drivers still off at ack rise", addr_oe_o, 0);
        @(negedge clk);
        check(addr_oe_o == '0 && cpu_stall_o, "R8 drivers off one cycle after",
              {addr_oe_o, cpu_stall_o}, 1);
        @(negedge clk);
        check(addr_oe_o == '1 && !cpu_stall_o, "R8 drivers back after two cycles",
              {addr_oe_o, cpu_stall_o}, {{NPORT{1'b1}}, 1'b0});
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int got;
        int seed;
        bit ok;
        seed = 7;
        void'($urandom(seed));
        tick(3);
        // R1 reset state
        @(negedge clk);
        check(gnt_ack_n_o && !cpu_stall_o && addr_oe_o == '1 && !proc_clk_o, "R1 reset state",
              {gnt_ack_n_o, cpu_stall_o, addr_oe_o, proc_clk_o}, {1'b1, 1'b0, {NPORT{1'b1}}, 1'b0});
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        prev_clk = proc_clk_o;
        tick(1);
        mon_on = 1'b1;

        // R3 basic grant with the bus idle
        cpu_addr_i = 16'hA55A; cpu_rd_n_i = 1'b0;
        req_n_i = 1'b0;
        wait_ack(1'b0, LIMIT, got);
        check(got >= 0, "R3 ack within bound", got, LIMIT);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gnt_ack_n_o) ok = 1'b0;
        end
        check(ok, "R3 ack held while request low", gnt_ack_n_o, 0);
        release_and_check();
        cpu_rd_n_i = 1'b1;

        // R7 request during a busy bus cycle
        cpu_busy_i = 1'b1; cpu_wr_n_i = 1'b0;
        req_n_i = 1'b0;
        tick(20);
        @(negedge clk);
        check(gnt_ack_n_o, "R7 no grant while busy", gnt_ack_n_o, 1);
        check(cpu_stall_o, "R7 CPU stalled once request seen", cpu_stall_o, 1);
        check(!wr_n_o, "R7 strobe still CPU-driven while draining", wr_n_o, 0);
        @(posedge clk);
        #1;
        cpu_busy_i = 1'b0; cpu_wr_n_i = 1'b1;
        wait_ack(1'b0, LIMIT, got);
        check(got >= 0, "R7 grant after cycle ends", got, LIMIT);
        release_and_check();

        // R2 feature disabled
        grant_en_i = 1'b0; cpu_rd_n_i = 1'b0;
        req_n_i = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!gnt_ack_n_o || cpu_stall_o || rd_n_o) ok = 1'b0;
        end
        check(ok, "R2 ignored when disabled", {gnt_ack_n_o, cpu_stall_o, rd_n_o}, 3'b100);
        @(posedge clk);
        #1;
        // R2 acknowledge pin in alternate use
        grant_en_i = 1'b1; ack_alt_i = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!gnt_ack_n_o || cpu_stall_o || addr_oe_o != '1) ok = 1'b0;
        end
        check(ok, "R2 ignored in alternate mode", {gnt_ack_n_o, cpu_stall_o}, 2'b10);
        @(posedge clk);
        #1;
        req_n_i = 1'b1; ack_alt_i = 1'b0; cpu_rd_n_i = 1'b1;
        tick(6);

        // Random phase: independent toggling of request, busy and CPU values
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            #1;
            if ($urandom_range(0, 15) == 0) req_n_i = ~req_n_i;
            if ($urandom_range(0, 3) == 0) cpu_busy_i = $urandom_range(0, 1) == 1;
            cpu_addr_i    = ADDR_W'($urandom);
            cpu_data_i    = DATA_W'($urandom);
            cpu_data_oe_i = $urandom_range(0, 1) == 1;
            cpu_rd_n_i    = $urandom_range(0, 1) == 1;
            cpu_wr_n_i    = $urandom_range(0, 1) == 1;
        end
        req_n_i = 1'b1; cpu_busy_i = 1'b0;
        wait_ack(1'b1, LIMIT, got);
        check(got >= 0, "R8 ack high after random phase", got, LIMIT);
        tick(6);
        @(negedge clk);
        check(!cpu_stall_o && addr_oe_o == '1, "R8 bus back after random phase",
              {cpu_stall_o, addr_oe_o}, {1'b0, {NPORT{1'b1}}});
        finish_run();
    end
endmodule